// File: doc/BRIEF.md
# Dual-Rate Peripheral Clock Enable Generator

This block derives single-cycle clock-enable strobes for a processor core and seven peripherals (CAN controller, watchdog, counter array, serial port, and timers 0, 1 and 2) from one master clock. Nothing is gated. Every consumer runs on the master clock and advances only in cycles where its enable is high.

An 8-bit rate register is written and read over a simple strobe bus. Bit 0 selects fast mode. When fast mode is off, the core and every peripheral get one strobe per 12 master cycles. When fast mode is on, the core gets one strobe per 6 master cycles, and each peripheral's own bit selects 6 periods (bit clear) or 12 periods (bit set) for that peripheral. The peripheral bits have no effect while fast mode is off.

All strobes come from one shared modulo-12 phase counter, so every output keeps the same phase as the others. A write is stored at once and can be read back at once. It reaches the strobes only at the next phase-0 boundary.

Top module: `dual_rate_clken`

## Requirements
- R1: After reset the rate register reads 0x00, and every enable output pulses once per 12 master cycles.
- R2: The register bits are as follows. Bit 0 is fast mode. Bit 1 is timer 0, bit 2 is timer 1, bit 3 is timer 2, bit 4 is the serial port, bit 5 is the counter array, bit 6 is the watchdog and bit 7 is CAN. Bit n (n≥1) controls `periph_en_o[n-1]`.
- R3: With bit 0 clear, `cpu_en_o` and all seven peripheral enables pulse once per 12 master cycles.
- R4: With bit 0 set, `cpu_en_o` pulses once per 6 master cycles.
- R5: With bit 0 set, a peripheral whose bit is 0 pulses once per 6 master cycles.
- R6: With bit 0 set, a peripheral whose bit is 1 pulses once per 12 master cycles.
- R7: With bit 0 clear, the peripheral bits have no effect: every peripheral enable equals `cpu_en_o` in every cycle.
- R8: Every enable pulse lasts exactly one master cycle.
- R9: Every peripheral pulse coincides with a `cpu_en_o` pulse. All 12-period strobes fire in the same cycle.
- R10: A write takes effect at the next phase-0 boundary. Strobe timing in the current 12-cycle frame does not change.
- R11: While `rd_en_i` is high, `rdata_o` returns the last written value, including peripheral bits that are currently ignored. While `rd_en_i` is low, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| cpu_en_o | output | 1 | Core machine-cycle enable |
| periph_en_o | output | 7 | Peripheral enables: [0] timer 0, [1] timer 1, [2] timer 2, [3] serial, [4] counter array, [5] watchdog, [6] CAN |

## Verification
The deferred update is the hardest behaviour to reach from the ports, because the phase counter is not visible. The stimulus first locks onto the phase in slow mode: in that mode a `cpu_en_o` pulse marks phase 0. It then switches on fast mode three cycles later. The bench checks that no extra pulse appears at phase 6 of that frame, and that pulses at phase 6 do appear from the next frame on. The rate checks count pulses over 24-cycle windows that start after one full frame of settling, so the result does not depend on where a window starts.

// File: rtl/clken_pkg.sv
package clken_pkg;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned N_PERIPH  = CFG_W - 1;
  localparam int unsigned FAST_BIT  = 0;
  localparam int unsigned SLOW_DIV  = 12;
  localparam int unsigned FAST_DIV  = SLOW_DIV / 2;
endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int unsigned DIV = 12,
  localparam int unsigned CW = $clog2(DIV),
  localparam int unsigned HALF = DIV / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic at_zero_o,
  output logic at_half_o,
  output logic at_last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1))     cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  assign at_zero_o = (cnt_q == '0);
  assign at_half_o = (cnt_q == CW'(HALF));
  assign at_last_o = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/rate_cfg_reg.sv
module rate_cfg_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_en_i,
  input  logic         boundary_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] stored_q, act_q, stored_d;

  assign stored_d = wr_en_i ? wdata_i : stored_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stored_q <= '0;
      act_q    <= '0;
    end else begin
      stored_q <= stored_d;
      // last cycle of frame: next value becomes live at phase 0
      if (boundary_i) act_q <= stored_d;
    end
  end

  assign rdata_o = rd_en_i ? stored_q : '0;
  assign act_o   = act_q;
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
  parameter int unsigned N = 7
) (
  input  logic         at_zero_i,
  input  logic         at_half_i,
  input  logic         fast_i,
  input  logic [N-1:0] slow_sel_i,
  output logic         cpu_en_o,
  output logic [N-1:0] periph_en_o
);
  assign cpu_en_o = at_zero_i | (fast_i & at_half_i);

  for (genvar g = 0; g < N; g++) begin : g_periph
    logic use_fast;
    assign use_fast       = fast_i & ~slow_sel_i[g];
    assign periph_en_o[g] = at_zero_i | (use_fast & at_half_i);
  end
endmodule

// File: rtl/dual_rate_clken.sv
module dual_rate_clken
  import clken_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [CFG_W-1:0]    wdata_i,
  output logic [CFG_W-1:0]    rdata_o,
  output logic                cpu_en_o,
  output logic [N_PERIPH-1:0] periph_en_o
);
  logic             at_zero, at_half, at_last;
  logic [CFG_W-1:0] act_cfg;

  phase_counter #(.DIV(SLOW_DIV)) i_phase (
    .clk_i, .rst_ni,
    .at_zero_o(at_zero), .at_half_o(at_half), .at_last_o(at_last)
  );

  rate_cfg_reg #(.W(CFG_W)) i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wdata_i, .rd_en_i,
    .boundary_i(at_last), .rdata_o, .act_o(act_cfg)
  );

  strobe_gen #(.N(N_PERIPH)) i_strobe (
    .at_zero_i(at_zero), .at_half_i(at_half),
    .fast_i(act_cfg[FAST_BIT]),
    .slow_sel_i(act_cfg[CFG_W-1:1]),
    .cpu_en_o, .periph_en_o
  );
endmodule

// File: rtl/dual_rate_clken_chk.sv
module dual_rate_clken_chk
  import clken_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [CFG_W-1:0]    wdata_i,
  input logic [CFG_W-1:0]    rdata_o,
  input logic                cpu_en_o,
  input logic [N_PERIPH-1:0] periph_en_o,
  input logic [CFG_W-1:0]    act_cfg_i
);
  logic       live_q, seen_q;
  logic [4:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      live_q <= 1'b1;
      if (cpu_en_o) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  AST_CPU_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |=> !cpu_en_o);  // R8
  AST_PERIPH_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |periph_en_o |=> ((periph_en_o & $past(periph_en_o)) == '0));  // R8
  AST_PERIPH_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |periph_en_o |-> cpu_en_o);  // R9
  AST_SLOW_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_cfg_i[FAST_BIT] |-> periph_en_o == {N_PERIPH{cpu_en_o}});  // R7
  AST_CPU_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_en_o && seen_q) |-> (gap_q == 5'(FAST_DIV - 1) || gap_q == 5'(SLOW_DIV - 1)));  // R4
  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(wr_en_i) && !wr_en_i && rd_en_i) |-> rdata_o == $past(wdata_i));  // R11
  AST_READ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);  // R11
endmodule

bind dual_rate_clken dual_rate_clken_chk i_chk (
  .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .wdata_i, .rdata_o,
  .cpu_en_o, .periph_en_o, .act_cfg_i(act_cfg)
);

// File: tb/test_dual_rate_clken.sv
`timescale 1ns/1ps
module test_dual_rate_clken;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       cpu_en_o;
  logic [6:0] periph_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  dual_rate_clken i_dual_rate_clken (.*);

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_reg(logic [7:0] v);
    @(negedge clk_i); wr_en_i = 1'b1; wdata_i = v;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic read_check(logic [7:0] exp, string req);
    @(negedge clk_i); rd_en_i = 1'b1; #1;
    check(rdata_o == exp, req, "readback", rdata_o, exp);
    @(negedge clk_i); rd_en_i = 1'b0; #1;
    check(rdata_o == 8'h00, req, "read idle", rdata_o, 0);
  endtask

  // settle one frame, then count pulses over 24 cycles
  task automatic measure(string req, int exp_cpu, logic [6:0] slow_mask, bit uniform);
    int cpu_n = 0;
    int per_n [7];
    int bad_w = 0, bad_a = 0, bad_u = 0;
    logic       prev_c = 1'b0;
    logic [6:0] prev_p = '0;
    foreach (per_n[k]) per_n[k] = 0;
    repeat (12) @(negedge clk_i);
    for (int c = 0; c < 24; c++) begin
      @(negedge clk_i);
      if (cpu_en_o) cpu_n++;
      for (int k = 0; k < 7; k++) if (periph_en_o[k]) per_n[k]++;
      if ((prev_c && cpu_en_o) || ((prev_p & periph_en_o) != '0)) bad_w++;
      if ((periph_en_o != '0) && !cpu_en_o) bad_a++;
      if (uniform && periph_en_o != {7{cpu_en_o}}) bad_u++;
      prev_c = cpu_en_o; prev_p = periph_en_o;
    end
    check(cpu_n == exp_cpu, req, "cpu pulses/24", cpu_n, exp_cpu);
    for (int k = 0; k < 7; k++)
      check(per_n[k] == (slow_mask[k] ? 2 : 4), req, $sformatf("periph%0d pulses/24", k),
            per_n[k], slow_mask[k] ? 2 : 4);
    check(bad_w == 0, "R8", "multi-cycle pulses", bad_w, 0);
    check(bad_a == 0, "R9", "misaligned periph pulses", bad_a, 0);
    if (uniform) check(bad_u == 0, "R7", "periph differs from cpu", bad_u, 0);
  endtask

  task automatic t_reset;
    @(negedge clk_i); rd_en_i = 1'b1; #1;
    check(rdata_o == 8'h00, "R1", "reset readback", rdata_o, 0);
    rd_en_i = 1'b0;
    measure("R1", 2, 7'h7F, 1'b1);
  endtask

  task automatic t_slow_ignored;
    write_reg(8'hFE);
    read_check(8'hFE, "R11");
    measure("R7", 2, 7'h7F, 1'b1);
    write_reg(8'h00);
    measure("R3", 2, 7'h7F, 1'b1);
  endtask

  task automatic t_fast_all;
    write_reg(8'h01);
    read_check(8'h01, "R2");
    measure("R5", 4, 7'h00, 1'b0);
  endtask

  task automatic t_fast_mixed;
    // bits 2,4,6 set -> timer1, serial, watchdog stay at 12
    write_reg(8'h55);
    read_check(8'h55, "R2");
    measure("R6", 4, 7'b0101010, 1'b0);
    write_reg(8'h81);
    measure("R6", 4, 7'b1000000, 1'b0);
    write_reg(8'hFF);
    measure("R4", 4, 7'h7F, 1'b0);
  endtask

  task automatic t_deferred;
    write_reg(8'h00);
    repeat (13) @(negedge clk_i);
    while (!cpu_en_o) @(negedge clk_i);  // phase 0
    repeat (3) @(negedge clk_i);         // phase 3
    wr_en_i = 1'b1; wdata_i = 8'h01;
    @(negedge clk_i); wr_en_i = 1'b0;    // phase 4
    repeat (2) @(negedge clk_i);         // phase 6
    check(!cpu_en_o, "R10", "cpu pulse at phase 6 before boundary", cpu_en_o, 0);
    check(periph_en_o == '0, "R10", "periph at phase 6 before boundary", periph_en_o, 0);
    repeat (6) @(negedge clk_i);         // phase 0
    check(cpu_en_o, "R10", "cpu pulse at boundary", cpu_en_o, 1);
    repeat (6) @(negedge clk_i);         // phase 6, new rate live
    check(cpu_en_o, "R10", "cpu pulse at phase 6 after boundary", cpu_en_o, 1);
    check(periph_en_o == 7'h7F, "R10", "periph at phase 6 after boundary", periph_en_o, 127);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_slow_ignored();
    t_fast_all();
    t_fast_mixed();
    t_deferred();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule